// File: doc/BRIEF.md
# Display Pixel FIFO with Underflow Recovery

This block buffers pixel words between a memory fetch engine and the display output path, all on one clock. The fetch engine writes words in on `wr_valid`; the display side pulls one word per `rd_req`. Whenever the fill level is at or below a programmable watermark and no burst is outstanding, the block pulses `burst_req` to ask the fetch engine for another burst of `BURST` words. The reset value of the watermark leaves room for two bursts and a three-word margin: `DEPTH - (2*BURST + 3)`.

Three events are latched in a sticky status vector: a read from an empty FIFO (underflow), a write into a full FIFO (overwrite, the word is dropped) and a bus error reported by the fetch engine. A small write-only command port sets or clears interrupt enables, acknowledges status bits and loads the watermark. An underflow does more than raise a flag. The FIFO is flushed and any outstanding burst is abandoned. `flush_o` tells the fetch engine to restart from the top of the frame, and display reads are held off until a full burst has arrived again, so the picture does not shift sideways.

Top module: `pixel_fifo_top`

## Requirements
- R1: While `rst` is high and in the cycle after it, `fill_level`, `irq_status`, `irq_enable`, `irq`, `burst_req`, `rd_valid` and `flush_o` are 0, and `threshold` equals DEPTH-(2*BURST+3), which is 493 for the defaults.
- R2: Words leave in the order they were accepted. A `rd_req` that is honoured (FIFO not empty, not resynchronising) gives `rd_valid`=1 with the word on `rd_data` in the following cycle.
- R3: `burst_req` is a one-cycle pulse raised after an edge at which no burst was in flight and `fill_level` <= `threshold`. After that, no new request is made until BURST writes have been seen, a bus error occurs, or a flush occurs.
- R4: A write while `fill_level` equals DEPTH is dropped, the level stays at DEPTH, and status bit 1 (overwrite) is set.
- R5: A `rd_req` while the FIFO is empty and not resynchronising sets status bit 0 (underflow). At the same edge it empties the FIFO, discards a write arriving in that cycle and abandons the in-flight burst. `flush_o` is high for the next cycle.
- R6: After an underflow, `rd_req` is ignored (no `rd_valid`, no new underflow) until `fill_level` has reached BURST. Reads are honoured from the cycle after that.
- R7: `bus_err` sets status bit 2 (memory error) and ends the in-flight burst, so a new request can follow one cycle later.
- R8: A command write with `reg_wr`=1 acts on `reg_op`: 0 ORs `reg_wdata[2:0]` into the enables, 1 clears the enables given by `reg_wdata[2:0]`, 2 clears the status bits given by `reg_wdata[2:0]`, and 3 loads `reg_wdata` into the watermark. An event in the same cycle as its clear wins.
- R9: Status bits stay set until cleared. `irq` is high exactly when some status bit is set whose enable bit is set.
- R10: With a lowered watermark, no request is made while `fill_level` is above it. A request follows once reads bring the level down to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Word from fetch engine |
| wr_data | input | WIDTH | Pixel word written |
| bus_err | input | 1 | Fetch engine reports a memory error |
| burst_req | output | 1 | One-cycle request for a new burst |
| flush_o | output | 1 | Restart-fetch pulse after underflow |
| rd_req | input | 1 | Display path asks for one word |
| rd_valid | output | 1 | rd_data holds a word this cycle |
| rd_data | output | WIDTH | Pixel word read |
| fill_level | output | $clog2(DEPTH+1) | Words currently held |
| reg_wr | input | 1 | Command strobe |
| reg_op | input | 2 | Command: 0 enable-set, 1 enable-clear, 2 status-clear, 3 watermark |
| reg_wdata | input | $clog2(DEPTH+1) | Command operand |
| irq_status | output | 3 | Sticky events: bit0 underflow, bit1 overwrite, bit2 memory error |
| irq_enable | output | 3 | Interrupt enables, same bit order |
| threshold | output | $clog2(DEPTH+1) | Current watermark |
| irq | output | 1 | Masked OR of status |

## Verification
Every input is registered once. Status, enables, watermark, fill level and read data therefore change at the first clock edge after the stimulus, and `irq` follows status in the same cycle. `burst_req` and `flush_o` come one edge later than the condition that causes them: the edge after a burst completes or a bus error arrives for a request, and the cycle after the underflow edge for a flush. The leaving of resynchronisation takes one extra edge after the level reaches a burst. Each bench task drives inputs on the falling edge and samples on the falling edge after the counted rising edges, inserting idle cycles where the watermark or resync state needs an edge to settle.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    typedef struct packed {
        logic mem_err;    // bit 2
        logic overwrite;  // bit 1
        logic underflow;  // bit 0
    } irq_bits_t;

    typedef enum logic [1:0] {
        OP_EN_SET  = 2'd0,
        OP_EN_CLR  = 2'd1,
        OP_ST_CLR  = 2'd2,
        OP_WMARK   = 2'd3
    } reg_op_t;

    function automatic int default_wmark(int depth, int burst);
        return depth - (2 * burst + 3);
    endfunction

endpackage

// File: rtl/pfifo_store.sv
module pfifo_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 32,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             overwrite
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic             full, wr_ok, rd_ok;

    assign full      = (level == LW'(DEPTH));
    assign empty     = (level == '0);
    assign wr_ok     = wr_en && !full && !flush;
    assign rd_ok     = rd_en && !empty && !flush;
    assign overwrite = wr_en && full && !flush;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
        if (rd_ok) rd_data <= mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr     <= '0;
            rptr     <= '0;
            level    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_ok;
            if (wr_ok) wptr <= bump(wptr);
            if (rd_ok) rptr <= bump(rptr);
            level <= level + LW'(wr_ok) - LW'(rd_ok);
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH)) else $error("level above depth"); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en && !flush) |=> level == LW'(DEPTH)) else $error("full write not dropped"); // R4
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> level == '0) else $error("flush left words"); // R5
    AST_VALID_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(level) != '0) else $error("read from empty"); // R2
endmodule

// File: rtl/pfifo_fetch.sv
module pfifo_fetch #(
    parameter int DEPTH = 512,
    parameter int BURST = 8,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int BW = (BURST > 1) ? $clog2(BURST) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] wmark,
    input  logic          wr_en,
    input  logic          bus_err,
    output logic          burst_req
);
    logic          inflight;
    logic [BW-1:0] beats;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            inflight  <= 1'b0;
            beats     <= '0;
            burst_req <= 1'b0;
        end else begin
            burst_req <= 1'b0;
            if (!inflight) begin
                if (level <= wmark) begin
                    burst_req <= 1'b1;
                    inflight  <= 1'b1;
                    beats     <= '0;
                end
            end else if (bus_err) begin
                inflight <= 1'b0;
            end else if (wr_en) begin
                if (beats == BW'(BURST - 1)) begin
                    inflight <= 1'b0;
                    beats    <= '0;
                end else begin
                    beats <= beats + 1'b1;
                end
            end
        end
    end

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        burst_req |=> !burst_req) else $error("request longer than one cycle"); // R3
    AST_REQ_WMARK: assert property (@(posedge clk) disable iff (rst)
        burst_req |-> $past(level <= wmark)) else $error("request above watermark"); // R10
    AST_REQ_ONE_OUT: assert property (@(posedge clk) disable iff (rst)
        burst_req |-> inflight) else $error("request without burst tracking"); // R3
endmodule

// File: rtl/pfifo_irq.sv
module pfifo_irq #(
    parameter int DEPTH = 512,
    parameter int BURST = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pfifo_pkg::irq_bits_t ev,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_op,
    input  logic [LW-1:0]        reg_wdata,
    output pfifo_pkg::irq_bits_t status,
    output pfifo_pkg::irq_bits_t enable,
    output logic [LW-1:0]        wmark,
    output logic                 irq
);
    import pfifo_pkg::*;

    irq_bits_t operand, clr;
    reg_op_t   op;

    assign op      = reg_op_t'(reg_op);
    assign operand = irq_bits_t'(reg_wdata[2:0]);
    assign clr     = (reg_wr && op == OP_ST_CLR) ? operand : '0;
    assign irq     = |(status & enable);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
            wmark  <= LW'(default_wmark(DEPTH, BURST));
        end else begin
            status <= (status & ~clr) | ev;
            if (reg_wr) begin
                case (op)
                    OP_EN_SET: enable <= enable | operand;
                    OP_EN_CLR: enable <= enable & ~operand;
                    OP_WMARK:  wmark  <= reg_wdata;
                    default:   ;
                endcase
            end
        end
    end

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((status & $past(ev)) == $past(ev))) else $error("event lost"); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && op == OP_ST_CLR) |=> ((status & $past(status)) == $past(status))) else $error("status dropped"); // R9
endmodule

// File: rtl/pixel_fifo_top.sv
module pixel_fifo_top #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 32,
    parameter int BURST = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             bus_err,
    output logic             burst_req,
    output logic             flush_o,
    input  logic             rd_req,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic [LW-1:0]    fill_level,
    input  logic             reg_wr,
    input  logic [1:0]       reg_op,
    input  logic [LW-1:0]    reg_wdata,
    output logic [2:0]       irq_status,
    output logic [2:0]       irq_enable,
    output logic [LW-1:0]    threshold,
    output logic             irq
);
    import pfifo_pkg::*;

    logic      resync, empty, ovw, underflow, rd_en;
    irq_bits_t ev, status, enable;

    assign underflow = rd_req && !resync && empty;
    assign rd_en     = rd_req && !resync;

    always_ff @(posedge clk) begin
        if (rst) begin
            resync  <= 1'b0;
            flush_o <= 1'b0;
        end else begin
            flush_o <= underflow;
            if (underflow)
                resync <= 1'b1;
            else if (resync && fill_level >= LW'(BURST))
                resync <= 1'b0;
        end
    end

    pfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst(rst), .flush(underflow),
        .wr_en(wr_valid), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .level(fill_level), .empty(empty), .overwrite(ovw)
    );

    pfifo_fetch #(.DEPTH(DEPTH), .BURST(BURST)) u_fetch (
        .clk(clk), .rst(rst), .flush(underflow),
        .level(fill_level), .wmark(threshold),
        .wr_en(wr_valid), .bus_err(bus_err), .burst_req(burst_req)
    );

    assign ev.underflow = underflow;
    assign ev.overwrite = ovw;
    assign ev.mem_err   = bus_err;

    pfifo_irq #(.DEPTH(DEPTH), .BURST(BURST)) u_irq (
        .clk(clk), .rst(rst), .ev(ev),
        .reg_wr(reg_wr), .reg_op(reg_op), .reg_wdata(reg_wdata),
        .status(status), .enable(enable), .wmark(threshold), .irq(irq)
    );

    assign irq_status = status;
    assign irq_enable = enable;

    AST_RESYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        resync |=> !rd_valid) else $error("read during resync"); // R6
    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> $past(rd_req) && fill_level == '0) else $error("flush without underflow"); // R5
endmodule

// File: tb/pixel_fifo_top_test.sv
`timescale 1ns/1ps
module pixel_fifo_top_test;
    localparam int DEPTH = 512;
    localparam int WIDTH = 32;
    localparam int BURST = 8;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_valid = 1'b0, bus_err = 1'b0, rd_req = 1'b0, reg_wr = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [1:0] reg_op = '0;
    logic [LW-1:0] reg_wdata = '0;
    logic burst_req, flush_o, rd_valid, irq;
    logic [WIDTH-1:0] rd_data;
    logic [LW-1:0] fill_level, threshold;
    logic [2:0] irq_status, irq_enable;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pixel_fifo_top #(.DEPTH(DEPTH), .WIDTH(WIDTH), .BURST(BURST)) uut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .bus_err(bus_err), .burst_req(burst_req), .flush_o(flush_o),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .fill_level(fill_level), .reg_wr(reg_wr), .reg_op(reg_op),
        .reg_wdata(reg_wdata), .irq_status(irq_status), .irq_enable(irq_enable),
        .threshold(threshold), .irq(irq)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_valid = 0; bus_err = 0; rd_req = 0; reg_wr = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(int n, logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_data  = base + i;
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pop_one(output logic v, output logic [31:0] d);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        v = rd_valid;
        d = rd_data;
    endtask

    task automatic reg_cmd(logic [1:0] op, logic [LW-1:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_op = op; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "fill", 32'(fill_level), 0);
        check("R1", "status", 32'(irq_status), 0);
        check("R1", "enable", 32'(irq_enable), 0);
        check("R1", "irq", 32'(irq), 0);
        check("R1", "watermark", 32'(threshold), 493);
        check("R1", "burst_req", 32'(burst_req), 0);
        rst = 1'b0;
    endtask

    task automatic t_request();
        do_reset();
        @(negedge clk);
        check("R3", "first request", 32'(burst_req), 1);
        @(negedge clk);
        check("R3", "request is a pulse", 32'(burst_req), 0);
        push(BURST, 32'h10);
        check("R3", "no request mid-burst", 32'(burst_req), 0);
        @(negedge clk);
        check("R3", "request after burst done", 32'(burst_req), 1);
    endtask

    task automatic t_order();
        logic v; logic [31:0] d;
        int bad = 0;
        do_reset();
        push(5, 32'hA00);
        check("R2", "fill after 5 writes", 32'(fill_level), 5);
        for (int i = 0; i < 5; i++) begin
            pop_one(v, d);
            if (!v || d !== 32'hA00 + i) bad++;
        end
        check("R2", "order of 5 words", bad, 0);
        check("R2", "fill after reads", 32'(fill_level), 0);
    endtask

    task automatic t_overwrite();
        logic v; logic [31:0] d;
        int bad = 0;
        do_reset();
        push(DEPTH, 32'h1000);
        check("R4", "status before overflow", 32'(irq_status[1]), 0);
        push(1, 32'hDEAD);
        check("R4", "fill stays full", 32'(fill_level), DEPTH);
        check("R4", "overwrite bit", 32'(irq_status[1]), 1);
        for (int i = 0; i < DEPTH; i++) begin
            pop_one(v, d);
            if (!v || d !== 32'h1000 + i) bad++;
        end
        check("R4", "dropped word absent, order kept", bad, 0);
    endtask

    task automatic t_underflow();
        logic v; logic [31:0] d;
        do_reset();
        reg_cmd(2'd0, 1);
        @(negedge clk);
        rd_req = 1'b1; wr_valid = 1'b1; wr_data = 32'h55;
        @(negedge clk);
        rd_req = 1'b0; wr_valid = 1'b0;
        check("R5", "underflow bit", 32'(irq_status), 1);
        check("R5", "flush pulse", 32'(flush_o), 1);
        check("R5", "same-cycle write discarded", 32'(fill_level), 0);
        check("R9", "irq with enabled underflow", 32'(irq), 1);
        @(negedge clk);
        check("R5", "flush one cycle", 32'(flush_o), 0);
        check("R9", "status sticky", 32'(irq_status), 1);
        reg_cmd(2'd2, 1);
        check("R8", "status cleared", 32'(irq_status), 0);
        check("R9", "irq drops", 32'(irq), 0);
        push(3, 32'h100);
        pop_one(v, d);
        check("R6", "read ignored in resync", 32'(v), 0);
        check("R6", "no new underflow", 32'(irq_status), 0);
        check("R6", "fill kept", 32'(fill_level), 3);
        push(BURST - 3, 32'h103);
        @(negedge clk);
        pop_one(v, d);
        check("R6", "read after refill valid", 32'(v), 1);
        check("R6", "first word after refill", d, 32'h100);
    endtask

    task automatic t_bus_err();
        do_reset();
        @(negedge clk);
        check("R7", "initial request", 32'(burst_req), 1);
        bus_err = 1'b1;
        @(negedge clk);
        bus_err = 1'b0;
        check("R7", "memory error bit", 32'(irq_status), 4);
        check("R7", "no request yet", 32'(burst_req), 0);
        @(negedge clk);
        check("R7", "request after error", 32'(burst_req), 1);
    endtask

    task automatic t_regs();
        do_reset();
        reg_cmd(2'd0, 7);
        check("R8", "enable set", 32'(irq_enable), 7);
        reg_cmd(2'd1, 2);
        check("R8", "enable clear", 32'(irq_enable), 5);
        @(negedge clk);
        bus_err = 1'b1; reg_wr = 1'b1; reg_op = 2'd2; reg_wdata = 4;
        @(negedge clk);
        bus_err = 1'b0; reg_wr = 1'b0;
        check("R8", "event beats clear", 32'(irq_status), 4);
        check("R9", "irq on enabled bit", 32'(irq), 1);
        reg_cmd(2'd1, 4);
        check("R9", "irq masked", 32'(irq), 0);
        check("R9", "status kept when masked", 32'(irq_status), 4);
    endtask

    task automatic t_wmark();
        logic v; logic [31:0] d;
        int stray = 0;
        do_reset();
        reg_cmd(2'd3, 4);
        check("R8", "watermark loaded", 32'(threshold), 4);
        push(BURST, 32'h200);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (burst_req) stray++;
        end
        check("R10", "no request above watermark", stray, 0);
        for (int i = 0; i < 4; i++) begin
            pop_one(v, d);
            if (burst_req) stray++;
        end
        check("R10", "no request before level reached", stray, 0);
        @(negedge clk);
        check("R10", "request at watermark", 32'(burst_req), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_request();
        t_order();
        t_overwrite();
        t_underflow();
        t_bus_err();
        t_regs();
        t_wmark();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule